// File: doc/BRIEF.md
# Subsleep Power-Mode Controller

This block is the power-mode state machine of a small 8-bit microcontroller running on its subclock. It tracks four modes: active, subactive, subsleep, and a stub that stands for all the other power-down modes. Software moves the core between active and subactive with a clock-select level. A sleep-instruction strobe issued in subactive enters subsleep only when three control bits agree. Any other combination of those bits sends the block to the stub.

In subsleep, the block gates off the clocks of the A/D converter and the PWM unit. It raises hold flags for the retained register and RAM state and for the I/O output levels. It stays in subsleep until one of two things happens. The first is an interrupt source whose enable bit is set while the global interrupt mask is clear. That request is first resynchronised to the subclock, then the block returns to subactive and pulses an exception-start strobe for one cycle. The second is a low level on the reset pin, which returns the block asynchronously to active.

Top module: `subsleep_pmc`

## Requirements
- R1: While `rst_pin_n` is low, `mode` is 2'b00 (active), both peripheral clock enables are 1, both hold flags are 0 and `exc_start` is 0.
- R2: In active, `clk_sel_sub` high moves `mode` to 2'b01 (subactive) on the next rising edge. In subactive, `clk_sel_sub` low moves it back to 2'b00.
- R3: In subactive, `sleep_strobe` with `cfg_standby_sel`=0, `cfg_lowspeed_on`=1 and `cfg_tmr_clksel`=1 moves `mode` to 2'b10 (subsleep) on the next rising edge.
- R4: A `sleep_strobe` in subactive with any other combination of the three bits, or any `sleep_strobe` in active, moves `mode` to 2'b11 (stub). The stub ignores clock-select, sleep and interrupt inputs and is left only by reset.
- R5: In subsleep and in the stub, `adc_clk_en` and `pwm_clk_en` are 0 and `hold_state` and `hold_io` are 1. In active and subactive they are 1,1 and 0,0.
- R6: In subsleep, a request on `irq_req[i]` with `irq_en[i]`=1 and `global_mask`=0, presented before rising edge E1, raises `exc_start` and sets `mode` to 2'b01 at edge E2. That is one to two subclock periods later. `exc_start` falls at the following edge.
- R7: In subsleep, while `global_mask` is 1, enabled requests neither end subsleep nor raise `exc_start`. Clearing the mask while a request is held lets the wake proceed.
- R8: In subsleep, a request whose enable bit is 0 neither ends subsleep nor raises `exc_start`.
- R9: A `sleep_strobe` in subsleep leaves `mode` at 2'b10. Interrupt requests in active or subactive never raise `exc_start`.
- R10: A low level on `rst_pin_n` while in subsleep returns `mode` to 2'b00 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subclock |
| rst_pin_n | input | 1 | Active-low reset pin, asynchronous |
| clk_sel_sub | input | 1 | 1 selects subactive, 0 selects active |
| sleep_strobe | input | 1 | One-cycle sleep-instruction strobe |
| cfg_standby_sel | input | 1 | Standby-select control bit |
| cfg_lowspeed_on | input | 1 | Low-speed-on control bit |
| cfg_tmr_clksel | input | 1 | Timer clock-select control bit |
| global_mask | input | 1 | CPU global interrupt mask |
| irq_req | input | NSRC | Interrupt requests, asynchronous |
| irq_en | input | NSRC | Per-source interrupt enables |
| mode | output | 2 | 00 active, 01 subactive, 10 subsleep, 11 stub |
| adc_clk_en | output | 1 | A/D converter clock enable |
| pwm_clk_en | output | 1 | PWM clock enable |
| hold_state | output | 1 | Register/RAM retention flag |
| hold_io | output | 1 | I/O output hold flag |
| exc_start | output | 1 | One-cycle exception-start strobe on wake |

## Verification
A wrong mode register shows at once at the ports. `mode` and all four gating and hold flags are decoded from it and change on the edge after the faulty transition. A stuck or shortened synchroniser moves the rising edge of `exc_start` off the second edge after the request, so the bench samples every cycle around that edge. A qualification fault, such as an ignored mask or enable, appears within two cycles as an unexpected exit from subsleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_SUBACT   = 2'b01,
        PM_SUBSLEEP = 2'b10,
        PM_STUB     = 2'b11
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     exc;
    } fsm_state_t;
endpackage

// File: rtl/pmc_irq_sync.sv
module pmc_irq_sync #(
    parameter int W      = 19,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_async,
    output logic [W-1:0] req_sync
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = req_async;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign req_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
    parameter int W = 19
) (
    input  logic [W-1:0] req_sync,
    input  logic [W-1:0] req_en,
    input  logic         mask,
    output logic         wake_hit
);
    logic [W-1:0] live;

    always_comb begin
        live     = req_sync & req_en;
        wake_hit = (|live) & ~mask;
    end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clk_sel_sub,
    input  logic     sleep,
    input  logic     standby_sel,
    input  logic     lowspeed_on,
    input  logic     tmr_clksel,
    input  logic     wake_hit,
    output pm_mode_e mode_q,
    output logic     exc_q
);
    fsm_state_t st_d, st_q;
    logic       sub_ok;

    always_comb begin
        sub_ok  = ~standby_sel & lowspeed_on & tmr_clksel;
        st_d    = st_q;
        st_d.exc = 1'b0;
        unique case (st_q.mode)
            PM_ACTIVE: begin
                if (sleep)            st_d.mode = PM_STUB;
                else if (clk_sel_sub) st_d.mode = PM_SUBACT;
            end
            PM_SUBACT: begin
                if (sleep)             st_d.mode = sub_ok ? PM_SUBSLEEP : PM_STUB;
                else if (!clk_sel_sub) st_d.mode = PM_ACTIVE;
            end
            PM_SUBSLEEP: begin
                if (wake_hit) begin
                    st_d.mode = PM_SUBACT;
                    st_d.exc  = 1'b1;
                end
            end
            PM_STUB: st_d.mode = PM_STUB;
            default: st_d.mode = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: PM_ACTIVE, exc: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign exc_q  = st_q.exc;

    // R3
    subsleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == PM_SUBSLEEP) |-> $past(mode_q == PM_SUBACT && sleep));

    // R6
    exc_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |-> (mode_q == PM_SUBACT) && $past(mode_q == PM_SUBSLEEP));

    // R6
    exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |=> !exc_q);

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_SUBACT && $past(mode_q == PM_SUBSLEEP)) |-> exc_q);

    // R4
    stub_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_q == PM_STUB) |-> mode_q == PM_STUB);
endmodule

// File: rtl/subsleep_pmc.sv
module subsleep_pmc
    import pmc_pkg::*;
#(
    parameter int NSRC        = 19,
    parameter int SYNC_STAGES = 1
) (
    input  logic            clk,
    input  logic            rst_pin_n,
    input  logic            clk_sel_sub,
    input  logic            sleep_strobe,
    input  logic            cfg_standby_sel,
    input  logic            cfg_lowspeed_on,
    input  logic            cfg_tmr_clksel,
    input  logic            global_mask,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    output logic [1:0]      mode,
    output logic            adc_clk_en,
    output logic            pwm_clk_en,
    output logic            hold_state,
    output logic            hold_io,
    output logic            exc_start
);
    logic [NSRC-1:0] req_sync;
    logic            wake_hit;
    pm_mode_e        cur_mode;
    logic            parked;

    pmc_irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_pin_n),
        .req_async (irq_req),
        .req_sync  (req_sync)
    );

    pmc_wake_qual #(.W(NSRC)) u_qual (
        .req_sync (req_sync),
        .req_en   (irq_en),
        .mask     (global_mask),
        .wake_hit (wake_hit)
    );

    pmc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_pin_n),
        .clk_sel_sub (clk_sel_sub),
        .sleep       (sleep_strobe),
        .standby_sel (cfg_standby_sel),
        .lowspeed_on (cfg_lowspeed_on),
        .tmr_clksel  (cfg_tmr_clksel),
        .wake_hit    (wake_hit),
        .mode_q      (cur_mode),
        .exc_q       (exc_start)
    );

    always_comb begin
        parked     = (cur_mode == PM_SUBSLEEP) || (cur_mode == PM_STUB);
        mode       = cur_mode;
        adc_clk_en = ~parked;
        pwm_clk_en = ~parked;
        hold_state = parked;
        hold_io    = parked;
    end

    // R5
    gate_vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (adc_clk_en || pwm_clk_en) |-> !hold_io);

    // R9
    no_exc_awake_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (cur_mode != PM_SUBSLEEP) |=> !exc_start || $past(cur_mode == PM_SUBSLEEP));
endmodule

// File: tb/subsleep_pmc_tb.sv
module subsleep_pmc_tb;
    localparam int N = 19;
    logic clk = 1'b0, rst_pin_n = 1'b0;
    logic clk_sel_sub = 0, sleep_strobe = 0;
    logic cfg_standby_sel = 0, cfg_lowspeed_on = 0, cfg_tmr_clksel = 0, global_mask = 0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic [1:0] mode;
    logic adc_clk_en, pwm_clk_en, hold_state, hold_io, exc_start;
    int checks = 0, failures = 0;

    subsleep_pmc #(.NSRC(N)) u_dut (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_pin_n = 0;
        nc(2);
        rst_pin_n = 1;
        nc(1);
    endtask

    task automatic to_subsleep();
        clk_sel_sub = 1; nc(1);
        cfg_standby_sel = 0; cfg_lowspeed_on = 1; cfg_tmr_clksel = 1;
        sleep_strobe = 1; nc(1); sleep_strobe = 0;
    endtask

    task automatic t_reset();
        nc(2);
        chk("R1 mode", mode, 2'b00);
        chk("R1 gates", {adc_clk_en, pwm_clk_en, hold_state, hold_io}, 4'b1100);
        chk("R1 exc", exc_start, 0);
        rst_pin_n = 1; nc(1);
    endtask

    task automatic t_clk_select();
        clk_sel_sub = 1; nc(1);
        chk("R2 to subactive", mode, 2'b01);
        chk("R5 subactive gates", {adc_clk_en, pwm_clk_en, hold_state, hold_io}, 4'b1100);
        clk_sel_sub = 0; nc(1);
        chk("R2 to active", mode, 2'b00);
    endtask

    task automatic t_enter_and_wake();
        to_subsleep();
        chk("R3 subsleep", mode, 2'b10);
        chk("R5 subsleep gates", {adc_clk_en, pwm_clk_en, hold_state, hold_io}, 4'b0011);
        sleep_strobe = 1; nc(1); sleep_strobe = 0;
        chk("R9 sleep in subsleep", mode, 2'b10);
        irq_en[5] = 1; irq_req[5] = 1; nc(1);
        chk("R6 no wake after one edge", {mode, exc_start}, {2'b10, 1'b0});
        nc(1);
        chk("R6 wake at second edge", {mode, exc_start}, {2'b01, 1'b1});
        nc(1);
        chk("R6 strobe one cycle", {mode, exc_start}, {2'b01, 1'b0});
        irq_req = '0; irq_en = '0;
        do_reset();
    endtask

    task automatic t_mask();
        int seen = 0;
        to_subsleep();
        global_mask = 1; irq_en[18] = 1; irq_req[18] = 1;
        for (int i = 0; i < 5; i++) begin nc(1); seen += exc_start; end
        chk("R7 masked stays", mode, 2'b10);
        chk("R7 masked no strobe", seen, 0);
        global_mask = 0; nc(1);
        chk("R7 unmask wakes", {mode, exc_start}, {2'b01, 1'b1});
        irq_req = '0; irq_en = '0;
        do_reset();
    endtask

    task automatic t_disabled();
        int seen = 0;
        to_subsleep();
        irq_en = '1; irq_en[3] = 0; irq_req[3] = 1;
        for (int i = 0; i < 5; i++) begin nc(1); seen += exc_start; end
        chk("R8 disabled stays", mode, 2'b10);
        chk("R8 disabled no strobe", seen, 0);
        #1 rst_pin_n = 0; #1;
        chk("R10 async reset", mode, 2'b00);
        chk("R1 reset gates", {adc_clk_en, pwm_clk_en, hold_state, hold_io}, 4'b1100);
        irq_req = '0; irq_en = '0; clk_sel_sub = 0;
        nc(1); rst_pin_n = 1; nc(1);
    endtask

    task automatic t_awake_irq();
        int seen = 0;
        irq_en = '1; irq_req = '1;
        for (int i = 0; i < 4; i++) begin nc(1); seen += exc_start; end
        clk_sel_sub = 1;
        for (int i = 0; i < 4; i++) begin nc(1); seen += exc_start; end
        chk("R9 no strobe awake", seen, 0);
        chk("R9 subactive kept", mode, 2'b01);
        irq_req = '0; irq_en = '0; clk_sel_sub = 0; nc(1);
    endtask

    task automatic t_stub();
        clk_sel_sub = 1; nc(1);
        cfg_standby_sel = 1; cfg_lowspeed_on = 1; cfg_tmr_clksel = 1;
        sleep_strobe = 1; nc(1); sleep_strobe = 0;
        chk("R4 standby bit to stub", mode, 2'b11);
        chk("R5 stub gates", {adc_clk_en, pwm_clk_en, hold_state, hold_io}, 4'b0011);
        clk_sel_sub = 0; irq_en = '1; irq_req = '1; nc(4);
        chk("R4 stub sticky", {mode, exc_start}, {2'b11, 1'b0});
        irq_req = '0; irq_en = '0;
        do_reset();
        clk_sel_sub = 1; nc(1);
        cfg_standby_sel = 0; cfg_lowspeed_on = 1; cfg_tmr_clksel = 0;
        sleep_strobe = 1; nc(1); sleep_strobe = 0;
        chk("R4 timer bit to stub", mode, 2'b11);
        clk_sel_sub = 0; do_reset();
        sleep_strobe = 1; nc(1); sleep_strobe = 0;
        chk("R4 sleep in active to stub", mode, 2'b11);
        do_reset();
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_clk_select();
        t_enter_and_wake();
        t_mask();
        t_disabled();
        t_awake_irq();
        t_stub();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule